// File: doc/BRIEF.md
# Path-Compressed Trie Longest-Prefix Lookup Engine

This engine resolves a 32-bit destination address to a next-hop index by walking a path-compressed binary trie in a local node memory. Chains of single-child nodes have been removed when the table was built, so every node names the one address bit that decides the branch. The bits between two tested positions are never looked at during the descent. A node can carry a prefix. Because bits were skipped on the way down, such a node checks its whole stored prefix against the leading bits of the address before the prefix can count as a match.

A lookup enters through a valid/ready request port and leaves through a valid/ready result port. The result carries either the next hop of the longest prefix matched along the path or a miss flag. Software or a table builder fills the node memory through a simple write port, one node per cycle. Building the trie and updating it while a lookup runs are outside this block.

Top module: `trie_lpm_engine`

## Requirements
- R1: Every lookup starts at node 0. At each node the address bit chosen by the node's test-bit field is examined, where index 0 is the address MSB (address bit 31) and index k is address bit 31-k. A 0 follows the low child pointer and a 1 follows the high child pointer.
- R2: At a node with the prefix flag set, the address matches when its leading L bits equal the leading L bits of the stored prefix, with L the node's prefix-length field. Length 0 matches every address, and any length of 32 or more compares all 32 bits. A match makes that node's next hop the best result so far, and the walk continues.
- R3: A prefix comparison that fails at a marked node ends the lookup at once. The result is the best match remembered before that node.
- R4: The lookup also ends when the chosen direction's child-valid flag is 0, which includes leaves, or when the chosen child pointer is not below NODE_CNT. The result is then the best match found so far.
- R5: When no node on the path matched, the result has res_miss = 1 and res_hop = 0. Otherwise it has res_miss = 0 and res_hop is the best match's next hop.
- R6: Each visited node costs one clock cycle. If a request is accepted on clock edge A and the lookup visits k nodes, res_valid is high from edge A+k.
- R7: A lookup visits at most MAX_STEPS nodes. After the last allowed node it ends with the best match so far, even if a child pointer would continue the walk.
- R8: req_ready is high only when no lookup is in progress and no result is waiting. A result stays valid with stable res_hop and res_miss until res_ready is high on a clock edge, and req_ready is high again after that edge.
- R9: A write with wr_en high and wr_idx below NODE_CNT replaces that node on the clock edge. A write to an index at or above NODE_CNT changes no node.
- R10: After reset, req_ready is 1 and res_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Engine can accept a request |
| req_addr | input | 32 | Address to resolve |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_hop | output | 8 | Next hop of the longest match (0 on miss) |
| res_miss | output | 1 | No prefix matched |
| wr_en | input | 1 | Node write strobe |
| wr_idx | input | 6 | Node index to write |
| wr_test_bit | input | 5 | Address bit index tested at the node |
| wr_lo_ptr | input | 6 | Child taken when the tested bit is 0 |
| wr_hi_ptr | input | 6 | Child taken when the tested bit is 1 |
| wr_lo_ok | input | 1 | Low child exists |
| wr_hi_ok | input | 1 | High child exists |
| wr_is_pfx | input | 1 | Node carries a prefix |
| wr_pfx | input | 32 | Stored prefix, left aligned |
| wr_pfx_len | input | 6 | Prefix length in bits |
| wr_hop | input | 8 | Next hop of the node's prefix |

## Verification
The bench builds the engine with NODE_CNT = 16 and MAX_STEPS = 8. Sixteen nodes let random child pointers drawn from 0 to 19 land beyond the memory, which exercises the out-of-range exit. A write index of 20, which would alias node 4 if only the low index bits were decoded, tests the ignored-write rule. With a cap of eight steps, the loops that random pointers form reach the step limit within a few cycles. The random tables also mix prefix lengths above 32 and single-bit perturbations of a key, so lookups end through every exit (mismatch, leaf, missing child, bad pointer, cap) on deep and shallow paths.

// File: rtl/trie_lpm_pkg.sv
package trie_lpm_pkg;

    localparam int LPM_ADDR_W = 32;
    localparam int LPM_HOP_W  = 8;
    localparam int LPM_PTR_W  = 6;
    localparam int LPM_BIT_W  = $clog2(LPM_ADDR_W);
    localparam int LPM_LEN_W  = $clog2(LPM_ADDR_W + 1);

    typedef struct packed {
        logic [LPM_BIT_W-1:0]  test_bit;
        logic [LPM_PTR_W-1:0]  lo_ptr;
        logic [LPM_PTR_W-1:0]  hi_ptr;
        logic                  lo_ok;
        logic                  hi_ok;
        logic                  is_pfx;
        logic [LPM_ADDR_W-1:0] pfx;
        logic [LPM_LEN_W-1:0]  pfx_len;
        logic [LPM_HOP_W-1:0]  hop;
    } lpm_node_t;

    typedef struct packed {
        logic                 hit;
        logic                 fail;
        logic                 go;
        logic [LPM_PTR_W-1:0] next_ptr;
    } lpm_step_t;

    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_WALK = 2'd1,
        WS_DONE = 2'd2
    } walk_state_e;

    // Ones in the leading len bits; lengths at or above the width keep all bits.
    function automatic logic [LPM_ADDR_W-1:0] len_mask(input logic [LPM_LEN_W-1:0] len);
        if (int'(len) >= LPM_ADDR_W)
            return '1;
        return ~({LPM_ADDR_W{1'b1}} >> len);
    endfunction

    // Bit index 0 is the address MSB.
    function automatic logic pick_bit(input logic [LPM_ADDR_W-1:0] addr,
                                      input logic [LPM_BIT_W-1:0]  idx);
        logic [LPM_ADDR_W-1:0] shifted;
        shifted = addr << idx;
        return shifted[LPM_ADDR_W-1];
    endfunction

endpackage

// File: rtl/trie_node_mem.sv
module trie_node_mem
    import trie_lpm_pkg::*;
#(
    parameter int NODE_CNT = 64
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [LPM_PTR_W-1:0] wr_idx,
    input  lpm_node_t            wr_node,
    input  logic [LPM_PTR_W-1:0] rd_idx,
    output lpm_node_t            rd_node
);
    localparam int IDX_W = $clog2(NODE_CNT);

    lpm_node_t store [NODE_CNT];

    logic wr_in_range;
    assign wr_in_range = int'(wr_idx) < NODE_CNT;

    always_ff @(posedge clk) begin
        if (wr_en && wr_in_range)
            store[wr_idx[IDX_W-1:0]] <= wr_node;
    end

    assign rd_node = store[rd_idx[IDX_W-1:0]];

endmodule

// File: rtl/trie_node_eval.sv
module trie_node_eval
    import trie_lpm_pkg::*;
#(
    parameter int NODE_CNT = 64
) (
    input  lpm_node_t             node,
    input  logic [LPM_ADDR_W-1:0] addr,
    output lpm_step_t             step
);
    logic                 same;
    logic                 dir;
    logic                 child_ok;
    logic [LPM_PTR_W-1:0] child;

    always_comb begin
        same     = ((addr ^ node.pfx) & len_mask(node.pfx_len)) == '0;
        dir      = pick_bit(addr, node.test_bit);
        child    = dir ? node.hi_ptr : node.lo_ptr;
        child_ok = (dir ? node.hi_ok : node.lo_ok) && (int'(child) < NODE_CNT);

        step.hit      = node.is_pfx && same;
        step.fail     = node.is_pfx && !same;
        step.go       = child_ok;
        step.next_ptr = child;
    end

endmodule

// File: rtl/trie_walker.sv
module trie_walker
    import trie_lpm_pkg::*;
#(
    parameter int MAX_STEPS = LPM_ADDR_W + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [LPM_ADDR_W-1:0] req_addr,
    output logic                  res_valid,
    input  logic                  res_ready,
    output logic [LPM_HOP_W-1:0]  res_hop,
    output logic                  res_miss,
    output logic [LPM_PTR_W-1:0]  cur_ptr,
    output logic [LPM_ADDR_W-1:0] cur_addr,
    input  lpm_node_t             node,
    input  lpm_step_t             step
);
    localparam int STEP_W = $clog2(MAX_STEPS + 1);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(MAX_STEPS - 1);

    walk_state_e          state;
    logic [STEP_W-1:0]    steps;
    logic                 best_ok;
    logic [LPM_HOP_W-1:0] best_hop;
    logic [LPM_HOP_W-1:0] res_hop_q;
    logic                 res_miss_q;

    logic                 nxt_ok;
    logic [LPM_HOP_W-1:0] nxt_hop;
    logic                 stop;

    always_comb begin
        nxt_ok  = best_ok || step.hit;
        nxt_hop = step.hit ? node.hop : best_hop;
        stop    = step.fail || !step.go || (steps == LAST_STEP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= WS_IDLE;
            steps      <= '0;
            best_ok    <= 1'b0;
            best_hop   <= '0;
            cur_ptr    <= '0;
            cur_addr   <= '0;
            res_hop_q  <= '0;
            res_miss_q <= 1'b0;
        end else begin
            case (state)
                WS_IDLE: begin
                    if (req_valid) begin
                        cur_addr <= req_addr;
                        cur_ptr  <= '0;
                        steps    <= '0;
                        best_ok  <= 1'b0;
                        best_hop <= '0;
                        state    <= WS_WALK;
                    end
                end
                WS_WALK: begin
                    if (stop) begin
                        res_hop_q  <= nxt_ok ? nxt_hop : '0;
                        res_miss_q <= !nxt_ok;
                        state      <= WS_DONE;
                    end else begin
                        cur_ptr  <= step.next_ptr;
                        steps    <= steps + 1'b1;
                        best_ok  <= nxt_ok;
                        best_hop <= nxt_hop;
                    end
                end
                WS_DONE: begin
                    if (res_ready)
                        state <= WS_IDLE;
                end
                default: state <= WS_IDLE;
            endcase
        end
    end

    assign req_ready = (state == WS_IDLE);
    assign res_valid = (state == WS_DONE);
    assign res_hop   = res_hop_q;
    assign res_miss  = res_miss_q;

endmodule

// File: rtl/trie_lpm_engine.sv
module trie_lpm_engine
    import trie_lpm_pkg::*;
#(
    parameter int NODE_CNT  = 64,
    parameter int MAX_STEPS = LPM_ADDR_W + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [LPM_ADDR_W-1:0] req_addr,
    output logic                  res_valid,
    input  logic                  res_ready,
    output logic [LPM_HOP_W-1:0]  res_hop,
    output logic                  res_miss,
    input  logic                  wr_en,
    input  logic [LPM_PTR_W-1:0]  wr_idx,
    input  logic [LPM_BIT_W-1:0]  wr_test_bit,
    input  logic [LPM_PTR_W-1:0]  wr_lo_ptr,
    input  logic [LPM_PTR_W-1:0]  wr_hi_ptr,
    input  logic                  wr_lo_ok,
    input  logic                  wr_hi_ok,
    input  logic                  wr_is_pfx,
    input  logic [LPM_ADDR_W-1:0] wr_pfx,
    input  logic [LPM_LEN_W-1:0]  wr_pfx_len,
    input  logic [LPM_HOP_W-1:0]  wr_hop
);
    lpm_node_t             wr_node;
    lpm_node_t             rd_node;
    lpm_step_t             step;
    logic [LPM_PTR_W-1:0]  cur_ptr;
    logic [LPM_ADDR_W-1:0] cur_addr;

    always_comb begin
        wr_node.test_bit = wr_test_bit;
        wr_node.lo_ptr   = wr_lo_ptr;
        wr_node.hi_ptr   = wr_hi_ptr;
        wr_node.lo_ok    = wr_lo_ok;
        wr_node.hi_ok    = wr_hi_ok;
        wr_node.is_pfx   = wr_is_pfx;
        wr_node.pfx      = wr_pfx;
        wr_node.pfx_len  = wr_pfx_len;
        wr_node.hop      = wr_hop;
    end

    trie_node_mem #(.NODE_CNT(NODE_CNT)) mem_i (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_node (wr_node),
        .rd_idx  (cur_ptr),
        .rd_node (rd_node)
    );

    trie_node_eval #(.NODE_CNT(NODE_CNT)) eval_i (
        .node (rd_node),
        .addr (cur_addr),
        .step (step)
    );

    trie_walker #(.MAX_STEPS(MAX_STEPS)) walk_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .res_valid (res_valid),
        .res_ready (res_ready),
        .res_hop   (res_hop),
        .res_miss  (res_miss),
        .cur_ptr   (cur_ptr),
        .cur_addr  (cur_addr),
        .node      (rd_node),
        .step      (step)
    );

endmodule

// File: rtl/trie_lpm_chk.sv
module trie_lpm_chk
    import trie_lpm_pkg::*;
#(
    parameter int MAX_STEPS = LPM_ADDR_W + 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 res_valid,
    input logic                 res_ready,
    input logic [LPM_HOP_W-1:0] res_hop,
    input logic                 res_miss
);
    logic [15:0] walk_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            walk_cnt <= '0;
        else if (req_valid && req_ready)
            walk_cnt <= '0;
        else if (!req_ready && !res_valid && walk_cnt != 16'hFFFF)
            walk_cnt <= walk_cnt + 1'b1;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !res_valid)); // R10

    AST_READY_EXCL: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !res_valid); // R8

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready); // R8

    AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_hop) && $stable(res_miss))); // R8

    AST_MISS_HOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_miss) |-> (res_hop == '0)); // R5

    AST_STEP_CAP: assert property (@(posedge clk) disable iff (rst)
        $rose(res_valid) |-> (walk_cnt >= 16'd1 && int'(walk_cnt) <= MAX_STEPS)); // R7

endmodule

bind trie_lpm_engine trie_lpm_chk #(.MAX_STEPS(MAX_STEPS)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_hop   (res_hop),
    .res_miss  (res_miss)
);

// File: tb/trie_lpm_engine_tb_top.sv
module trie_lpm_engine_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NODE_CNT   = 16;
    localparam int MAX_STEPS  = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        res_valid;
    logic        res_ready = 1'b0;
    logic [7:0]  res_hop;
    logic        res_miss;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [4:0]  wr_test_bit = '0;
    logic [5:0]  wr_lo_ptr = '0;
    logic [5:0]  wr_hi_ptr = '0;
    logic        wr_lo_ok = 1'b0;
    logic        wr_hi_ok = 1'b0;
    logic        wr_is_pfx = 1'b0;
    logic [31:0] wr_pfx = '0;
    logic [5:0]  wr_pfx_len = '0;
    logic [7:0]  wr_hop = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // Bench copy of the table, written alongside the design.
    logic [4:0]  m_bit [NODE_CNT];
    logic [5:0]  m_lo  [NODE_CNT];
    logic [5:0]  m_hi  [NODE_CNT];
    logic        m_lok [NODE_CNT];
    logic        m_hok [NODE_CNT];
    logic        m_pfx [NODE_CNT];
    logic [31:0] m_val [NODE_CNT];
    logic [5:0]  m_len [NODE_CNT];
    logic [7:0]  m_hop [NODE_CNT];

    always #(CLK_PERIOD/2) clk = ~clk;

    trie_lpm_engine #(.NODE_CNT(NODE_CNT), .MAX_STEPS(MAX_STEPS)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .res_valid(res_valid), .res_ready(res_ready), .res_hop(res_hop), .res_miss(res_miss),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_test_bit(wr_test_bit),
        .wr_lo_ptr(wr_lo_ptr), .wr_hi_ptr(wr_hi_ptr), .wr_lo_ok(wr_lo_ok), .wr_hi_ok(wr_hi_ok),
        .wr_is_pfx(wr_is_pfx), .wr_pfx(wr_pfx), .wr_pfx_len(wr_pfx_len), .wr_hop(wr_hop)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wn(input int idx, input int tbit, input int lo, input int hi,
                      input bit lok, input bit hok, input bit mk,
                      input logic [31:0] pfx, input int len, input int hop);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'(idx); wr_test_bit = 5'(tbit);
        wr_lo_ptr = 6'(lo); wr_hi_ptr = 6'(hi); wr_lo_ok = lok; wr_hi_ok = hok;
        wr_is_pfx = mk; wr_pfx = pfx; wr_pfx_len = 6'(len); wr_hop = 8'(hop);
        if (idx < NODE_CNT) begin
            m_bit[idx] = 5'(tbit); m_lo[idx] = 6'(lo); m_hi[idx] = 6'(hi);
            m_lok[idx] = lok; m_hok[idx] = hok; m_pfx[idx] = mk;
            m_val[idx] = pfx; m_len[idx] = 6'(len); m_hop[idx] = 8'(hop);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clear_table();
        for (int i = 0; i < NODE_CNT; i++)
            wn(i, 0, 0, 0, 0, 0, 0, 32'h0, 0, 0);
    endtask

    // Expected result from the requirements: bitwise prefix compare, MSB-first index.
    task automatic model(input logic [31:0] a, output logic [7:0] hop,
                         output bit miss, output int steps);
        int  p;
        bit  ok;
        bit  match;
        bit  dir;
        int  nxt;
        bit  nok;
        p = 0; ok = 0; hop = 0; steps = 0;
        while (1) begin
            steps++;
            if (m_pfx[p]) begin
                match = 1;
                for (int i = 0; i < 32; i++)
                    if (i < int'(m_len[p]) && a[31-i] != m_val[p][31-i]) match = 0;
                if (!match) break;
                ok = 1; hop = m_hop[p];
            end
            if (steps == MAX_STEPS) break;
            dir = a[31 - int'(m_bit[p])];
            nxt = dir ? int'(m_hi[p]) : int'(m_lo[p]);
            nok = dir ? m_hok[p] : m_lok[p];
            if (!nok || nxt >= NODE_CNT) break;
            p = nxt;
        end
        miss = !ok;
        if (miss) hop = 0;
    endtask

    task automatic lookup(input logic [31:0] a, input int hold, input string tag);
        logic [7:0] ehop;
        bit         emiss;
        int         esteps;
        int         cyc;
        logic [7:0] first_hop;
        model(a, ehop, emiss, esteps);
        @(negedge clk);
        check({tag, " R8 ready before request"}, 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R8 busy after accept"}, 32'(req_ready), 32'd0);
        cyc = 0;
        while (!res_valid && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        check({tag, " R6 latency"}, 32'(cyc), 32'(esteps));
        check({tag, " R5 miss flag"}, 32'(res_miss), 32'(emiss));
        check({tag, " R2 next hop"}, 32'(res_hop), 32'(ehop));
        first_hop = res_hop;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            check({tag, " R8 result held"}, {23'd0, res_valid, res_hop}, {23'd0, 1'b1, first_hop});
        end
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        check({tag, " R8 ready after take"}, 32'(req_ready), 32'd1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] key;
        void'($urandom(32'd20417));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 reset ready", 32'(req_ready), 32'd1);
        check("R10 reset no result", 32'(res_valid), 32'd0);

        // Example table: a=0 b=01000 c=011 d=1 e=100 f..i=1100..1111.
        clear_table();
        wn(0, 0, 1, 2, 1, 1, 0, 32'h0, 0, 0);
        wn(1, 2, 3, 4, 1, 1, 1, 32'h00000000, 1, 1);
        wn(3, 0, 0, 0, 0, 0, 1, 32'h40000000, 5, 2);
        wn(4, 0, 0, 0, 0, 0, 1, 32'h60000000, 3, 3);
        wn(2, 1, 5, 6, 1, 1, 1, 32'h80000000, 1, 4);
        wn(5, 0, 0, 0, 0, 0, 1, 32'h80000000, 3, 5);
        wn(6, 2, 7, 8, 1, 1, 0, 32'h0, 0, 0);
        wn(7, 3, 9, 10, 1, 1, 0, 32'h0, 0, 0);
        wn(8, 3, 11, 12, 1, 1, 0, 32'h0, 0, 0);
        wn(9, 0, 0, 0, 0, 0, 1, 32'hC0000000, 4, 6);
        wn(10, 0, 0, 0, 0, 0, 1, 32'hD0000000, 4, 7);
        wn(11, 0, 0, 0, 0, 0, 1, 32'hE0000000, 4, 8);
        wn(12, 0, 0, 0, 0, 0, 1, 32'hF0000000, 4, 9);
        lookup(32'h58000000, 0, "R3 b mismatch keeps a");
        lookup(32'hB0000000, 2, "R3 e mismatch keeps d");
        lookup(32'h60000000, 0, "R1 leaf c");
        lookup(32'h40000000, 0, "R2 exact b");
        lookup(32'hD0000000, 3, "R1 deep g");
        lookup(32'hF1234567, 0, "R1 deep i");

        // Root prefix that fails: nothing matched.
        wn(0, 0, 1, 2, 1, 1, 1, 32'hE0000000, 3, 50);
        lookup(32'h58000000, 0, "R5 miss at root");
        // Length 0 matches all; no children ends at the root.
        wn(0, 0, 1, 2, 0, 0, 1, 32'h0, 0, 77);
        lookup(32'h9ABCDEF0, 0, "R4 zero length leaf");
        // Length above 32 compares all bits.
        wn(0, 0, 0, 0, 0, 0, 1, 32'h12345678, 40, 66);
        lookup(32'h12345678, 0, "R2 long length hit");
        lookup(32'h12345679, 0, "R2 long length miss");
        // Pointer beyond the memory ends the walk.
        wn(0, 0, 20, 20, 1, 1, 1, 32'h0, 0, 5);
        lookup(32'h0, 0, "R4 pointer out of range");
        // Ignored write: index 20 would alias node 4 if truncated.
        wn(0, 0, 4, 4, 1, 1, 1, 32'h0, 0, 5);
        wn(4, 0, 0, 0, 0, 0, 1, 32'h0, 0, 9);
        lookup(32'h0, 0, "R9 write lands");
        wn(20, 0, 0, 0, 0, 0, 1, 32'h0, 0, 99);
        lookup(32'h0, 0, "R9 ignored write");
        // Self loop hits the step cap.
        wn(0, 0, 0, 0, 1, 1, 1, 32'h0, 0, 3);
        lookup(32'h0, 1, "R7 step cap");

        // Random tables around a key.
        for (int t = 0; t < 40; t++) begin
            key = $urandom;
            for (int i = 0; i < NODE_CNT; i++) begin
                logic [31:0] flip;
                flip = ($urandom % 4 == 0) ? (32'h1 << ($urandom % 32)) : 32'h0;
                wn(i, int'($urandom % 32), int'($urandom % 20), int'($urandom % 20),
                   ($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 2) != 0,
                   key ^ flip, int'($urandom % 40), int'($urandom % 256));
            end
            for (int k = 0; k < 8; k++) begin
                logic [31:0] a;
                a = key ^ (($urandom % 3 == 0) ? (32'h1 << ($urandom % 32)) : 32'h0);
                lookup(a, int'($urandom % 2), "R1 random");
            end
        end

        finish_run();
    end

endmodule